// File: doc/BRIEF.md
# Multi-Rate Square-Wave FFSK Modulator

This block turns a serial bit stream into a phase-continuous fast frequency-shift-keyed tone, delivered as a single-bit square wave. It runs from a fixed reference clock. A clock-rate input tells the block whether that reference is 1.008 MHz or 4.032 MHz. Two rate-select inputs choose 1200, 2400 or 4800 baud. Each bit is sent as a fixed number of tone half-cycles, and each half-cycle lasts a whole number of reference clocks. So a bit at a given baud rate lasts the same real time whichever reference is used.

The block asks for data with a one-cycle request strobe in the last cycle of every bit. The next bit, together with the clock-rate and rate-select pins, is taken at the clock edge that closes that cycle. Pin changes made in the middle of a bit therefore have no effect until the next boundary. When the pins ask for 4800 baud on the slow reference, the block raises an error flag, forces the tone low and consumes no data until the configuration becomes legal.

Top module: `ffsk_square_mod`

## Requirements
- R1: Once reset is released, toneOut is 0, cfgError is 0 and bitReq is 1: the idle block asks for its first bit at once.
- R2: bitReq is high for exactly one cycle, the last cycle of each bit, and also in every idle or error cycle. The txBit value and the configuration pins are sampled at the rising edge that ends a cycle in which bitReq is high.
- R3: At 1200 baud (slowRateSel=1), a 1 bit is two half-cycles of 420·m clocks (one 1200 Hz cycle) and a 0 bit is three half-cycles of 280·m clocks (one and a half 1800 Hz cycles).
- R4: At 2400 baud (slowRateSel=0, fastRateSel=0), a 1 bit is one half-cycle of 420·m clocks and a 0 bit is two half-cycles of 210·m clocks.
- R5: At 4800 baud (slowRateSel=0, fastRateSel=1, clkRateFast=1), a 1 bit is one half-cycle of 840 clocks and a 0 bit is two half-cycles of 420 clocks.
- R6: The multiplier m is 4 when clkRateFast=1 (4.032 MHz) and 1 when it is 0 (1.008 MHz). A bit therefore lasts 840·m clocks at 1200 baud, 420·m at 2400 baud and 840 at 4800 baud.
- R7: toneOut toggles one cycle after the edge that starts each half-cycle, including the first half-cycle of a bit. It is never reset at a bit boundary, so the phase is continuous. The first half-cycle after idle or error drives it to 1.
- R8: 4800 baud requested with clkRateFast=0 is invalid. Sampled at a boundary, it sets cfgError to 1 and toneOut to 0 in the next cycle and starts no bit, so bitReq stays high every cycle. The next valid boundary clears cfgError.
- R9: Changes on clkRateFast, slowRateSel, fastRateSel and txBit in cycles where bitReq is 0 do not change toneOut, bitReq or cfgError.
- R10: With slowRateSel=1, fastRateSel is ignored and 1200 baud is used on either reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (1.008 or 4.032 MHz) |
| rstN | input | 1 | Active-low synchronous reset |
| clkRateFast | input | 1 | 1 = 4.032 MHz reference, 0 = 1.008 MHz |
| slowRateSel | input | 1 | 1 selects 1200 baud |
| fastRateSel | input | 1 | With slowRateSel=0: 1 = 4800 baud, 0 = 2400 baud |
| txBit | input | 1 | Next data bit, sampled when bitReq is high |
| bitReq | output | 1 | Bit request strobe at each bit boundary |
| toneOut | output | 1 | Square-wave FFSK tone |
| cfgError | output | 1 | Invalid rate/clock combination latched |

## Verification
bitReq is combinational from the bit counters, so it is due in the same cycle as the last clock of a bit. toneOut and cfgError are registers and change one cycle after the boundary or half-cycle edge that causes the change. The bench drives inputs and compares every output at the falling edge. It compares against a behavioural model that has already been advanced past the previous rising edge, so each expected value belongs to exactly the cycle being sampled. Bit lengths are also measured between request strobes and compared with lengths computed from tone frequencies and the reference rate.

// File: rtl/ffsk_pkg.sv
package ffsk_pkg;

  // Baud-rate selection decoded from the rate pins
  typedef enum logic [1:0] {
    BAUD_1200 = 2'd0,
    BAUD_2400 = 2'd1,
    BAUD_4800 = 2'd2
  } baudT;

  // Control-to-datapath strobes, at most one high per cycle
  typedef struct packed {
    logic bitStart;   // a valid bit begins at this edge
    logic halfStart;  // a further half-cycle of the current bit begins
    logic fault;      // boundary reached with an illegal configuration
  } strobeT;

endpackage

// File: rtl/ffsk_tone_path.sv
module ffsk_tone_path
  import ffsk_pkg::*;
#(
  parameter int BASE_HALF = 420,
  parameter int FAST_MULT = 4,
  parameter int CW        = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clkRateFast,
  input  logic          slowRateSel,
  input  logic          fastRateSel,
  input  logic          txBit,
  input  strobeT        strobe,
  output logic          cfgOk,
  output logic [CW-1:0] nextLen,
  output logic [1:0]    nextHalves,
  output logic          toneOut,
  output logic          cfgError
);

  // Half-cycle lengths on the slow reference, derived from the 1200 Hz half
  localparam logic [CW-1:0] LEN_1200 = CW'(BASE_HALF);
  localparam logic [CW-1:0] LEN_1800 = CW'((BASE_HALF * 2) / 3);
  localparam logic [CW-1:0] LEN_2400 = CW'(BASE_HALF / 2);
  localparam logic [CW-1:0] LEN_4800 = CW'(BASE_HALF / 4);
  localparam int            MULT_SH  = $clog2(FAST_MULT);

  baudT          rateSel;
  logic [CW-1:0] baseLen;
  logic [CW-1:0] scaledLen;
  logic          toneQ;
  logic          errQ;

  always_comb begin
    if (slowRateSel)      rateSel = BAUD_1200;
    else if (fastRateSel) rateSel = BAUD_4800;
    else                  rateSel = BAUD_2400;
    cfgOk = (rateSel != BAUD_4800) || clkRateFast;
    case (rateSel)
      BAUD_1200: begin
        baseLen    = txBit ? LEN_1200 : LEN_1800;
        nextHalves = txBit ? 2'd2 : 2'd3;
      end
      BAUD_2400: begin
        baseLen    = txBit ? LEN_1200 : LEN_2400;
        nextHalves = txBit ? 2'd1 : 2'd2;
      end
      default: begin
        baseLen    = txBit ? LEN_2400 : LEN_4800;
        nextHalves = txBit ? 2'd1 : 2'd2;
      end
    endcase
  end

  // Reference scaling: shift for a power-of-two ratio, multiply otherwise
  generate
    if ((FAST_MULT & (FAST_MULT - 1)) == 0) begin : g_shift
      assign scaledLen = baseLen << MULT_SH;
    end else begin : g_mult
      assign scaledLen = CW'(baseLen * FAST_MULT);
    end
  endgenerate

  assign nextLen = clkRateFast ? scaledLen : baseLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toneQ <= 1'b0;
      errQ  <= 1'b0;
    end else if (strobe.fault) begin
      toneQ <= 1'b0;
      errQ  <= 1'b1;
    end else if (strobe.bitStart || strobe.halfStart) begin
      toneQ <= ~toneQ;
      if (strobe.bitStart) errQ <= 1'b0;
    end
  end

  assign toneOut  = toneQ;
  assign cfgError = errQ;

  // R8
  fault_forces_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fault |=> (!toneOut && cfgError));

  // R7
  tone_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.bitStart && !strobe.halfStart && !strobe.fault) |=> $stable(toneOut));

  // R7
  tone_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bitStart || strobe.halfStart) |=> (toneOut != $past(toneOut)));

  // R8
  slow_4800_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkRateFast && !slowRateSel && fastRateSel) |-> !cfgOk);

endmodule

// File: rtl/ffsk_bit_ctrl.sv
module ffsk_bit_ctrl
  import ffsk_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgOk,
  input  logic [CW-1:0] nextLen,
  input  logic [1:0]    nextHalves,
  output strobeT        strobe,
  output logic          bitReq
);

  logic          active;
  logic [CW-1:0] halfTimer;
  logic [CW-1:0] curLen;
  logic [1:0]    halvesLeft;
  logic          halfDone;
  logic          boundary;

  assign halfDone = active && (halfTimer == CW'(1));
  assign boundary = !active || (halfDone && (halvesLeft == 2'd0));

  always_comb begin
    strobe.bitStart  = boundary && cfgOk;
    strobe.fault     = boundary && !cfgOk;
    strobe.halfStart = halfDone && (halvesLeft != 2'd0);
  end

  assign bitReq = boundary;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active     <= 1'b0;
      halfTimer  <= '0;
      curLen     <= '0;
      halvesLeft <= 2'd0;
    end else if (boundary) begin
      if (cfgOk) begin
        active     <= 1'b1;
        curLen     <= nextLen;
        halfTimer  <= nextLen;
        halvesLeft <= nextHalves - 2'd1;
      end else begin
        active     <= 1'b0;
        halfTimer  <= '0;
        halvesLeft <= 2'd0;
      end
    end else if (strobe.halfStart) begin
      halfTimer  <= curLen;
      halvesLeft <= halvesLeft - 2'd1;
    end else begin
      halfTimer <= halfTimer - CW'(1);
    end
  end

  // R2
  timer_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (halfTimer != '0));

  // R2
  bit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bitStart |=> (active && halfTimer == $past(nextLen)));

  // R9
  len_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !boundary) |=> $stable(curLen));

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

// File: rtl/ffsk_square_mod.sv
module ffsk_square_mod
  import ffsk_pkg::*;
#(
  parameter int BASE_HALF = 420,
  parameter int FAST_MULT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic clkRateFast,
  input  logic slowRateSel,
  input  logic fastRateSel,
  input  logic txBit,
  output logic bitReq,
  output logic toneOut,
  output logic cfgError
);

  localparam int CW = $clog2(BASE_HALF * FAST_MULT + 1);

  strobeT        strobe;
  logic          cfgOk;
  logic [CW-1:0] nextLen;
  logic [1:0]    nextHalves;

  ffsk_bit_ctrl #(.CW(CW)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgOk      (cfgOk),
    .nextLen    (nextLen),
    .nextHalves (nextHalves),
    .strobe     (strobe),
    .bitReq     (bitReq)
  );

  ffsk_tone_path #(
    .BASE_HALF (BASE_HALF),
    .FAST_MULT (FAST_MULT),
    .CW        (CW)
  ) path (
    .clk         (clk),
    .rstN        (rstN),
    .clkRateFast (clkRateFast),
    .slowRateSel (slowRateSel),
    .fastRateSel (fastRateSel),
    .txBit       (txBit),
    .strobe      (strobe),
    .cfgOk       (cfgOk),
    .nextLen     (nextLen),
    .nextHalves  (nextHalves),
    .toneOut     (toneOut),
    .cfgError    (cfgError)
  );

endmodule

// File: tb/ffsk_square_mod_test.sv
module ffsk_square_mod_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, clkRateFast, slowRateSel, fastRateSel, txBit;
  logic bitReq, toneOut, cfgError;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  int    halfQ[$];
  int    left = 0;
  logic  expTone = 1'b0;
  logic  expErr = 1'b0;
  string curTag = "R1";
  int    pendLen = 0;
  int    startCyc = 0;

  // scenario driven at bit boundaries
  logic       scnCf, scnS, scnF;
  logic [7:0] scnPat;
  int         bitIdx;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ffsk_square_mod uut (
    .clk(clk), .rstN(rstN), .clkRateFast(clkRateFast), .slowRateSel(slowRateSel),
    .fastRateSel(fastRateSel), .txBit(txBit), .bitReq(bitReq), .toneOut(toneOut),
    .cfgError(cfgError)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // Tone plan from frequencies: half length = refHz / (2 * toneHz)
  task automatic plan(input logic cf, input logic s, input logic f, input logic b,
                      output int len, output int n, output bit ok, output string tag);
    int refHz;
    int toneHz;
    refHz = cf ? 4032000 : 1008000;
    ok = 1;
    if (s) begin
      toneHz = b ? 1200 : 1800;
      n = b ? 2 : 3;
      tag = f ? "R10/R3/R6/R9" : "R3/R6/R9";
    end else if (!f) begin
      toneHz = b ? 1200 : 2400;
      n = b ? 1 : 2;
      tag = "R4/R6/R9";
    end else begin
      toneHz = b ? 2400 : 4800;
      n = b ? 1 : 2;
      tag = "R5/R9";
      ok = cf;
    end
    len = refHz / (2 * toneHz);
  endtask

  task automatic stepCycle();
    bit   expReq;
    int   len, n;
    bit   ok;
    string tag;
    expReq = (left <= 1) && (halfQ.size() == 0);
    // compare the current cycle
    check({curTag, " tone"}, toneOut, expTone);
    check("R8 cfgError", cfgError, expErr);
    check("R2 bitReq", bitReq, expReq);
    if (bitReq && pendLen > 0) begin
      check("R6 bit length", cyc - startCyc + 1, pendLen);
      pendLen = 0;
    end
    // drive inputs for the coming edge
    if (expReq) begin
      clkRateFast = scnCf;
      slowRateSel = scnS;
      fastRateSel = scnF;
      txBit = scnPat[bitIdx % 8];
      bitIdx++;
    end else begin
      {clkRateFast, slowRateSel, fastRateSel, txBit} = 4'($urandom);
    end
    // advance the model past the edge
    if (expReq) begin
      plan(clkRateFast, slowRateSel, fastRateSel, txBit, len, n, ok, tag);
      halfQ.delete();
      if (ok) begin
        for (int i = 1; i < n; i++) halfQ.push_back(len);
        left = len;
        expTone = ~expTone;
        expErr = 1'b0;
        curTag = tag;
        pendLen = len * n;
        startCyc = cyc + 1;
      end else begin
        left = 0;
        expTone = 1'b0;
        expErr = 1'b1;
        curTag = "R8";
        pendLen = 0;
      end
    end else if (left == 1) begin
      left = halfQ.pop_front();
      expTone = ~expTone;
    end else begin
      left--;
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic runScenario(input logic cf, input logic s, input logic f,
                             input logic [7:0] pat, input int nBits);
    scnCf = cf; scnS = s; scnF = f; scnPat = pat; bitIdx = 0;
    while (bitIdx < nBits) stepCycle();
  endtask

  initial begin
    rstN = 1'b0;
    clkRateFast = 1'b0; slowRateSel = 1'b1; fastRateSel = 1'b0; txBit = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 reset tone", toneOut, 0);
    check("R1 reset cfgError", cfgError, 0);
    check("R1 reset bitReq", bitReq, 1);
    runScenario(1'b0, 1'b1, 1'b0, 8'b0010_1101, 5);  // 1200 slow
    runScenario(1'b0, 1'b0, 1'b0, 8'b1100_1010, 6);  // 2400 slow
    runScenario(1'b1, 1'b0, 1'b1, 8'b0110_0101, 6);  // 4800 fast
    runScenario(1'b1, 1'b1, 1'b0, 8'b0000_1001, 4);  // 1200 fast
    runScenario(1'b1, 1'b0, 1'b0, 8'b0000_0110, 4);  // 2400 fast
    runScenario(1'b0, 1'b0, 1'b1, 8'b1111_1111, 6);  // illegal: R8
    runScenario(1'b0, 1'b0, 1'b0, 8'b0000_0101, 3);  // recover at 2400
    runScenario(1'b0, 1'b1, 1'b1, 8'b0000_0110, 3);  // R10 pin ignored
    runScenario(1'b1, 1'b1, 1'b1, 8'b0000_0011, 2);  // R10 on fast clock
    // let the last bit finish under checking
    repeat (3400) stepCycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule